// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Read-Clear

The block collects 24 interrupt request lines into one active-high interrupt output for a host that reacts to rising edges. The lines are grouped into three banks of eight: bank 0 carries sources 0 to 7, bank 1 sources 8 to 15 and bank 2 sources 16 to 23. Each bank has a one-byte enable mask (read/write) and a one-byte status register (read only). A source is pending when its status bit and its mask bit are both 1, and the output is the OR of every pending bit.

Every source except one, chosen by the parameter `LEVEL_SRC` (default 12, bank 1 bit 4), is edge-captured. Each request line first passes through a two-flop synchronizer. A 0-to-1 transition of the synchronized line sets a sticky status bit, but only if the source is enabled at that moment; an edge that arrives while the source is disabled is lost. Reading a bank's status register returns the value from before the read and clears that bank's captured bits, so no separate acknowledge exists. The level-sensitive source's status bit shows the synchronized live level and a read does not clear it.

Host access uses a plain synchronous byte bus. Status of bank b is at address 2b and its mask is at 2b+1. A read strobe registers the selected byte onto `rd_data` at the next clock edge, and `rd_data` holds it until the next read. Unmapped addresses read 0 and ignore writes. The bus has no back-pressure: each strobe takes exactly one cycle and is always accepted.

Top module: `irq_agg`

## Requirements
- R1: After reset all masks and status registers read 0x00 and `irq_out` is 0.
- R2: A write to address 2b+1 loads mask b, and a read of that address returns the written byte. Mask bit 1 enables the source and bit 0 disables it.
- R3: A 0-to-1 transition of an enabled edge source sets its status bit, which is bit (source mod 8) of status at address 2×(source div 8). A 1-to-0 transition sets nothing.
- R4: An edge on a disabled source is not recorded: enabling the source afterwards leaves its status bit 0 and `irq_out` 0.
- R5: A read of status b returns the value from before the read and clears all captured edge bits of bank b. The other banks are left unchanged.
- R6: An edge that is captured in the same cycle as a read-clear of its bank stays set after the read.
- R7: The status bit of source `LEVEL_SRC` follows the synchronized input level and a status read does not clear it.
- R8: `irq_out` is a register that is 1 exactly one cycle after any status bit AND its mask bit is 1, and 0 one cycle after no pending bit remains.
- R9: Writes to status addresses (2b) have no effect on any register or on `irq_out`.
- R10: Clearing a mask bit of a captured source drops it from `irq_out` but keeps the bit in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 24 | Interrupt request lines, asynchronous |
| addr | input | 3 | Register address: status b at 2b, mask b at 2b+1 |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, one cycle per read, triggers the read-clear |
| rd_data | output | 8 | Byte registered on the edge that samples `rd_en` |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are one-cycle strobes with `addr` valid in the same cycle and never both high together. The bench drives these pins only just after a falling clock edge and raises one strobe per access. The assertions also assume that the request lines may change at any time. They therefore reason only about the synchronized edge and capture signals, not about the raw pins. The stimulus holds each request high for several cycles, so the synchronizer always produces exactly one rising edge per pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BYTE_W = 8;

  // Low address bit selects the register kind inside a bank.
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int           W        = 8,
  parameter logic [W-1:0] LVL_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] level,
  input  logic         wr_mask,
  input  logic         rd_clr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] status,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] new_cap,
  output logic         pend_any
);
  logic [W-1:0] cap_d;

  // Edge bits are captured only while enabled; level bits never latch.
  assign new_cap = rise & mask_q & ~LVL_BITS;

  always_comb begin
    cap_d = rd_clr ? '0 : cap_q;
    cap_d = cap_d | new_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      cap_q <= cap_d;
      if (wr_mask) mask_q <= wr_data;
    end
  end

  assign status   = cap_q | (level & LVL_BITS);
  assign pend_any = |(status & mask_q);
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = BYTE_W,
  parameter int LEVEL_SRC = 12,
  localparam int NSRC     = NUM_BANKS * BANK_W,
  localparam int ADDR_W   = $clog2(2 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BANK_W-1:0] rd_data,
  output logic              irq_out
);
  localparam int BSEL_W = ADDR_W - 1;
  localparam logic [NSRC-1:0] LVL_ALL = NSRC'(1) << LEVEL_SRC;

  logic [NSRC-1:0] lvl_all, rise_all;
  logic [NSRC-1:0] mask_all, cap_all, new_all, stat_all;
  logic [NUM_BANKS-1:0] pend_vec;

  reg_kind_e         kind;
  logic [BSEL_W-1:0] sel_bank;
  logic [BANK_W-1:0] rd_mux;

  assign kind     = reg_kind_e'(addr[0]);
  assign sel_bank = addr[ADDR_W-1:1];

  irq_agg_sync #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (irq_src),
    .level (lvl_all),
    .rise  (rise_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (sel_bank == BSEL_W'(b));

    irq_agg_bank #(
      .W        (BANK_W),
      .LVL_BITS (LVL_ALL[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise_all[b*BANK_W +: BANK_W]),
      .level    (lvl_all[b*BANK_W +: BANK_W]),
      .wr_mask  (wr_en && hit && kind == REG_MASK),
      .rd_clr   (rd_en && hit && kind == REG_STATUS),
      .wr_data  (wr_data),
      .mask_q   (mask_all[b*BANK_W +: BANK_W]),
      .status   (stat_all[b*BANK_W +: BANK_W]),
      .cap_q    (cap_all[b*BANK_W +: BANK_W]),
      .new_cap  (new_all[b*BANK_W +: BANK_W]),
      .pend_any (pend_vec[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_bank == BSEL_W'(b)) begin
        rd_mux = (kind == REG_MASK) ? mask_all[b*BANK_W +: BANK_W]
                                    : stat_all[b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq_out <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq_out <= |pend_vec;
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic                        irq_out,
  input logic [NUM_BANKS*BANK_W-1:0] mask_all,
  input logic [NUM_BANKS*BANK_W-1:0] cap_all,
  input logic [NUM_BANKS*BANK_W-1:0] new_all,
  input logic [NUM_BANKS-1:0]        pend_vec
);
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_vec) |=> irq_out); // R8
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|pend_vec)); // R8
  AST_NO_MASKED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_all & ~$past(cap_all) & ~$past(mask_all)) == '0)); // R4
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_all)); // R2
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr[0]) |=> $stable(mask_all)); // R9

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(2 * b);
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ST_ADDR) |=>
      ((cap_all[b*BANK_W +: BANK_W] & ~$past(new_all[b*BANK_W +: BANK_W])) == '0)); // R5
    AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ST_ADDR) |=>
      ((~cap_all[b*BANK_W +: BANK_W] & $past(new_all[b*BANK_W +: BANK_W])) == '0)); // R6
  end
endmodule

bind irq_agg irq_agg_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .irq_out  (irq_out),
  .mask_all (mask_all),
  .cap_all  (cap_all),
  .new_all  (new_all),
  .pend_vec (pend_vec)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_src = '0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  irq_agg dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: compares each read result against the scoreboard queue.
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: read with empty scoreboard, got %02h", "monitor", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data=%02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called right after a falling edge; drives a one-cycle read.
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [23:0] bits);
    irq_src = irq_src | bits;
    cyc(4);
    irq_src = irq_src & ~bits;
    cyc(4);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out=%0b expected %0b", t, irq_out, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk_irq(1'b0, "R1");
    for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1");
    // R2 mask write and readback
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF); wr(3'd5, 8'h00);
    rd(3'd1, 8'hFF, "R2"); rd(3'd3, 8'hFF, "R2"); rd(3'd5, 8'h00, "R2");
    // R3 / R8 capture and output
    pulse(24'h000008);
    chk_irq(1'b1, "R8 set");
    rd(3'd0, 8'h08, "R3 R5 preclear");
    rd(3'd0, 8'h00, "R5 cleared");
    cyc(2);
    chk_irq(1'b0, "R8 clear");
    // R5 banks independent
    pulse(24'h000202);
    rd(3'd0, 8'h02, "R5 bank0");
    rd(3'd2, 8'h02, "R5 bank1 untouched");
    rd(3'd2, 8'h00, "R5 bank1 cleared");
    // R4 masked edge lost
    pulse(24'h020000);
    wr(3'd5, 8'h02);
    cyc(3);
    chk_irq(1'b0, "R4 irq");
    rd(3'd4, 8'h00, "R4 status");
    pulse(24'h020000);
    rd(3'd4, 8'h02, "R3 bank2 enabled");
    rd(3'd4, 8'h00, "R5 bank2 cleared");
    // R10 masking a captured bit
    pulse(24'h000020);
    chk_irq(1'b1, "R10 before mask");
    wr(3'd1, 8'hDF);
    cyc(2);
    chk_irq(1'b0, "R10 masked");
    rd(3'd0, 8'h20, "R10 status kept");
    wr(3'd1, 8'hFF);
    // R7 level source (source 12 = bank1 bit4)
    irq_src[12] = 1'b1;
    cyc(5);
    chk_irq(1'b1, "R7 irq");
    rd(3'd2, 8'h10, "R7 level");
    rd(3'd2, 8'h10, "R7 not cleared");
    irq_src[12] = 1'b0;
    cyc(5);
    rd(3'd2, 8'h00, "R7 follows low");
    chk_irq(1'b0, "R7 irq low");
    // R9 status writes ignored
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    cyc(2);
    chk_irq(1'b0, "R9 irq");
    rd(3'd0, 8'h00, "R9 status0");
    rd(3'd1, 8'hFF, "R9 mask0");
    rd(3'd3, 8'hFF, "R9 mask1");
    // R6 edge coincident with read-clear
    irq_src[6] = 1'b1;
    cyc(2);
    rd(3'd0, 8'h00, "R6 preclear");
    rd(3'd0, 8'h40, "R6 kept");
    irq_src[6] = 1'b0;
    // R3 falling edge sets nothing
    cyc(6);
    rd(3'd0, 8'h00, "R3 fall");
    cyc(2);
    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d reads outstanding expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule